// File: doc/BRIEF.md
# Banked Program Counter Branch Unit

This block carries out program-flow changes for a small processor core. The code address is 24 bits wide. It is made of a 16-bit program counter and an 8-bit code bank register. The surrounding core has already decoded the instruction and fetched every operand. It raises `start` for one cycle and presents the following inputs:

- an operation class;
- a 4-bit condition code;
- the five status flags;
- a signed 8-bit displacement;
- a 24-bit direct target;
- the accumulator;
- an indirect word and the bank byte that sits beside that word;
- a vector number;
- the length of the current instruction.

The unit works out where the next instruction lies. Relative and near transfers stay inside the current bank, and far transfers reload the bank. Calls push their return address through a word-wide stack write port, and the stack pointer is kept inside the block. A vector call reads its target from a 16-word table at the top of the current bank through a read port with one cycle of latency. When the work ends, the unit raises `done` for one cycle. In that same cycle the new program counter and bank are already visible, along with the number of cycles the operation took.

Top module: `bank_branch_unit`

## Requirements
- R1: During reset and after it, `pc` equals RESET_PC (0x1000), `bank` equals RESET_BANK (0x02), the stack pointer holds RESET_SP (0x8000), and `busy` and `done` are low.
- R2: Class 0 (conditional relative) is taken when the selected test holds. The flag bits are Z=bit0, C=bit1, N=bit2, V=bit3 and T=bit4. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 T, 9 !T, 10 V^N, 11 !(V^N), 12 (V^N)|Z, 13 !((V^N)|Z), 14 C|Z, 15 !(C|Z). Class 1 is always taken. `taken` reports the outcome when `done` is high.
- R3: For classes 0 and 1, the next address is `pc + instLen`. A taken branch loads that address plus the sign-extended displacement, with the sum wrapping modulo 2^16. A branch that is not taken loads the next address. The bank never changes.
- R4: `cycles`, and the number of clock edges from the accepting edge to the edge that raises `done`, are as follows: 4 for a taken relative branch, 3 for one not taken, 2 for any jump or unused class, 3 for a near call, 4 for a far call, and 5 for a vector call.
- R5: Near jumps load only `pc` and leave the bank unchanged. Class 2 loads from `accum`, class 3 from `target[15:0]`, and class 4 from `indWord`.
- R6: Far jumps load `pc` and `bank`. Class 5 takes them from `target[15:0]` and `target[23:16]`. Class 6 takes them from `indWord` and `indBank`.
- R7: Before each stack write, the stack pointer drops by 2, and `stkAddr` is the new value. A near call (class 7 from `target`, class 8 from `indWord`) writes one word, the next address. A far call (class 9 from `target`, class 10 from `indWord`/`indBank`) first writes the old bank, zero-extended, and then writes the next address at the word below it.
- R8: A vector call (class 11) reads address `{bank, 0xFFE0 + 2*(15 - vecNum)}` with `rdReq`. It takes `rdData` from the following cycle as the new `pc`, keeps the bank and pushes one return word.
- R9: `done` stays high for exactly one cycle. `pc` and `bank` change only on the edge that raises `done`.
- R10: A `start` that arrives while `busy` is high is ignored, and it produces neither a second result nor any change to the result in progress.
- R11: Classes 12 to 15 leave `pc`, `bank` and the stack untouched, report `taken` low, and finish in 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opClass | input | 4 | Operation class |
| condCode | input | 4 | Branch test selector |
| flags | input | 5 | {T,V,N,C,Z} |
| disp | input | 8 | Signed relative displacement |
| target | input | 24 | Direct target, bank in upper byte |
| accum | input | 16 | Accumulator value |
| indWord | input | 16 | Fetched indirect word |
| indBank | input | 8 | Byte at indirect operand offset +2 |
| vecNum | input | 4 | Vector number |
| instLen | input | 3 | Length of current instruction |
| rdData | input | 16 | Vector table read data, one cycle after rdReq |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 3 | Cycle count of the completed operation |
| taken | output | 1 | Transfer taken |
| pc | output | 16 | Program counter |
| bank | output | 8 | Code bank register |
| stkWe | output | 1 | Stack write strobe |
| stkAddr | output | 16 | Stack write address |
| stkData | output | 16 | Stack write data |
| rdReq | output | 1 | Vector table read request |
| rdAddr | output | 24 | Vector table read address |

## Verification
The hardest case to reach is a start request that arrives during the cycles of a longer operation. The bench keeps `start` high for two further cycles just after a far call is accepted, and it changes the class and the accumulator on those cycles. The scoreboard then expects exactly one result, with both stack words intact. Wrap-around of the relative target within the bank is forced by first jumping near the top or the bottom of the bank and then branching across the boundary. All sixteen tests are driven under several flag patterns, so each code sees both outcomes.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  localparam logic [3:0] OP_REL_COND   = 4'd0;
  localparam logic [3:0] OP_REL_ALWAYS = 4'd1;
  localparam logic [3:0] OP_JMP_ACC    = 4'd2;
  localparam logic [3:0] OP_JMP_DIR    = 4'd3;
  localparam logic [3:0] OP_JMP_IND    = 4'd4;
  localparam logic [3:0] OP_JMPF_DIR   = 4'd5;
  localparam logic [3:0] OP_JMPF_IND   = 4'd6;
  localparam logic [3:0] OP_CALL_DIR   = 4'd7;
  localparam logic [3:0] OP_CALL_IND   = 4'd8;
  localparam logic [3:0] OP_CALLF_DIR  = 4'd9;
  localparam logic [3:0] OP_CALLF_IND  = 4'd10;
  localparam logic [3:0] OP_CALL_VEC   = 4'd11;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DECODE, ST_EVAL, ST_RELPC, ST_PUSH1, ST_PUSH2,
    ST_VREAD, ST_VWAIT, ST_FINISH
  } seqStateT;

  typedef struct packed {
    logic capture;
    logic decode;
    logic evalCond;
    logic relAdd;
    logic vecRead;
    logic vecLatch;
    logic pushBank;
    logic pushPc;
    logic commit;
  } ctrlStrobeT;

  function automatic logic isRelative(input logic [3:0] op);
    return op == OP_REL_COND || op == OP_REL_ALWAYS;
  endfunction

  function automatic logic isJump(input logic [3:0] op);
    return op >= OP_JMP_ACC && op <= OP_JMPF_IND;
  endfunction

  function automatic logic isFarCall(input logic [3:0] op);
    return op == OP_CALLF_DIR || op == OP_CALLF_IND;
  endfunction

  function automatic logic isNearCall(input logic [3:0] op);
    return op == OP_CALL_DIR || op == OP_CALL_IND;
  endfunction

  function automatic logic isTransfer(input logic [3:0] op);
    return op <= OP_CALL_VEC;
  endfunction

endpackage

// File: rtl/bbu_cond.sv
module bbu_cond (
  input  logic [3:0] condCode,
  input  logic [4:0] flags,
  output logic       condHit
);
  logic fz, fc, fn, fv, ft;
  logic [7:0] baseTest;

  assign fz = flags[0];
  assign fc = flags[1];
  assign fn = flags[2];
  assign fv = flags[3];
  assign ft = flags[4];

  // Each code pair shares a base test; the low code bit inverts it.
  always_comb begin
    baseTest[0] = fz;
    baseTest[1] = fc;
    baseTest[2] = fn;
    baseTest[3] = fv;
    baseTest[4] = ft;
    baseTest[5] = fv ^ fn;
    baseTest[6] = (fv ^ fn) | fz;
    baseTest[7] = fc | fz;
  end

  assign condHit = baseTest[condCode[3:1]] ^ condCode[0];
endmodule

// File: rtl/bbu_ctrl.sv
module bbu_ctrl
  import bbu_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       opCur,
  input  logic             condHit,
  output ctrlStrobeT       strobe,
  output logic             busy,
  output logic             done,
  output logic [CYC_W-1:0] cycles
);
  seqStateT state, nextState;
  logic [CYC_W-1:0] cnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          nextState      = ST_DECODE;
        end
      end
      ST_DECODE: begin
        strobe.decode = 1'b1;
        if (isRelative(opCur))                      nextState = ST_EVAL;
        else if (isNearCall(opCur) || isFarCall(opCur)) nextState = ST_PUSH1;
        else if (opCur == OP_CALL_VEC)              nextState = ST_VREAD;
        else                                        nextState = ST_FINISH;
      end
      ST_EVAL: begin
        strobe.evalCond = 1'b1;
        nextState       = condHit ? ST_RELPC : ST_FINISH;
      end
      ST_RELPC: begin
        strobe.relAdd = 1'b1;
        nextState     = ST_FINISH;
      end
      ST_VREAD: begin
        strobe.vecRead = 1'b1;
        nextState      = ST_VWAIT;
      end
      ST_VWAIT: begin
        strobe.vecLatch = 1'b1;
        nextState       = ST_PUSH1;
      end
      ST_PUSH1: begin
        if (isFarCall(opCur)) begin
          strobe.pushBank = 1'b1;
          nextState       = ST_PUSH2;
        end else begin
          strobe.pushPc = 1'b1;
          nextState     = ST_FINISH;
        end
      end
      ST_PUSH2: begin
        strobe.pushPc = 1'b1;
        nextState     = ST_FINISH;
      end
      ST_FINISH: begin
        strobe.commit = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      done   <= 1'b0;
      cycles <= '0;
    end else begin
      state <= nextState;
      if (strobe.capture)
        cnt <= CYC_W'(1);
      else if (state != ST_IDLE)
        cnt <= cnt + CYC_W'(1);
      done <= strobe.commit;
      if (strobe.commit)
        cycles <= cnt;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bbu_datapath.sv
module bbu_datapath
  import bbu_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter int              BANK_W     = 8,
  parameter int              DISP_W     = 8,
  parameter int              VEC_W      = 4,
  parameter int              LEN_W      = 3,
  parameter logic [PC_W-1:0]   RESET_PC   = 16'h1000,
  parameter logic [BANK_W-1:0] RESET_BANK = 8'h02,
  parameter logic [PC_W-1:0]   RESET_SP   = 16'h8000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobeT               strobe,
  input  logic [3:0]               opClass,
  input  logic [3:0]               condCode,
  input  logic [4:0]               flags,
  input  logic [DISP_W-1:0]        disp,
  input  logic [PC_W+BANK_W-1:0]   target,
  input  logic [PC_W-1:0]          accum,
  input  logic [PC_W-1:0]          indWord,
  input  logic [BANK_W-1:0]        indBank,
  input  logic [VEC_W-1:0]         vecNum,
  input  logic [LEN_W-1:0]         instLen,
  input  logic [PC_W-1:0]          rdData,
  output logic [3:0]               opCur,
  output logic                     condHit,
  output logic                     taken,
  output logic [PC_W-1:0]          pc,
  output logic [BANK_W-1:0]        bank,
  output logic                     stkWe,
  output logic [PC_W-1:0]          stkAddr,
  output logic [PC_W-1:0]          stkData,
  output logic                     rdReq,
  output logic [PC_W+BANK_W-1:0]   rdAddr
);
  localparam int              ADDR_W    = PC_W + BANK_W;
  localparam int              VEC_SLOTS = 1 << VEC_W;
  localparam logic [PC_W-1:0] VEC_BASE  = ~PC_W'(2 * VEC_SLOTS - 1);

  logic [3:0]        condReg;
  logic [4:0]        flagReg;
  logic [DISP_W-1:0] dispReg;
  logic [ADDR_W-1:0] tgtReg;
  logic [PC_W-1:0]   accReg, indWordReg;
  logic [BANK_W-1:0] indBankReg;
  logic [VEC_W-1:0]  vecReg;
  logic [LEN_W-1:0]  lenReg;
  logic [PC_W-1:0]   calcPc, sp;
  logic [BANK_W-1:0] calcBank;

  logic [PC_W-1:0]   followPc, relPc, jumpPc, dispExt, vecOffset;
  logic [BANK_W-1:0] jumpBank;
  logic              testHit;

  bbu_cond condUnit (
    .condCode (condReg),
    .flags    (flagReg),
    .condHit  (testHit)
  );

  assign condHit  = (opCur == OP_REL_ALWAYS) | testHit;
  assign followPc = pc + PC_W'(lenReg);
  assign dispExt  = {{(PC_W-DISP_W){dispReg[DISP_W-1]}}, dispReg};
  assign relPc    = followPc + dispExt;

  always_comb begin
    jumpPc   = pc;
    jumpBank = bank;
    case (opCur)
      OP_JMP_ACC: jumpPc = accReg;
      OP_JMP_DIR, OP_CALL_DIR: jumpPc = tgtReg[PC_W-1:0];
      OP_JMP_IND, OP_CALL_IND: jumpPc = indWordReg;
      OP_JMPF_DIR, OP_CALLF_DIR: begin
        jumpPc   = tgtReg[PC_W-1:0];
        jumpBank = tgtReg[ADDR_W-1:PC_W];
      end
      OP_JMPF_IND, OP_CALLF_IND: begin
        jumpPc   = indWordReg;
        jumpBank = indBankReg;
      end
      default: ;
    endcase
  end

  // Table sits at the top of the bank; slot index is (slots-1) - vector.
  assign vecOffset = PC_W'({~vecReg, 1'b0});
  assign rdReq     = strobe.vecRead;
  assign rdAddr    = {bank, VEC_BASE + vecOffset};

  assign stkWe   = strobe.pushBank | strobe.pushPc;
  assign stkAddr = sp - PC_W'(2);
  assign stkData = strobe.pushBank ? PC_W'(bank) : followPc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCur      <= '0;
      condReg    <= '0;
      flagReg    <= '0;
      dispReg    <= '0;
      tgtReg     <= '0;
      accReg     <= '0;
      indWordReg <= '0;
      indBankReg <= '0;
      vecReg     <= '0;
      lenReg     <= '0;
      calcPc     <= RESET_PC;
      calcBank   <= RESET_BANK;
      taken      <= 1'b0;
      pc         <= RESET_PC;
      bank       <= RESET_BANK;
      sp         <= RESET_SP;
    end else begin
      if (strobe.capture) begin
        opCur      <= opClass;
        condReg    <= condCode;
        flagReg    <= flags;
        dispReg    <= disp;
        tgtReg     <= target;
        accReg     <= accum;
        indWordReg <= indWord;
        indBankReg <= indBank;
        vecReg     <= vecNum;
        lenReg     <= instLen;
      end
      if (strobe.decode) begin
        calcPc   <= jumpPc;
        calcBank <= jumpBank;
        taken    <= isTransfer(opCur);
      end
      if (strobe.evalCond) begin
        calcPc <= followPc;
        taken  <= condHit;
      end
      if (strobe.relAdd)
        calcPc <= relPc;
      if (strobe.vecLatch)
        calcPc <= rdData;
      if (stkWe)
        sp <= sp - PC_W'(2);
      if (strobe.commit) begin
        pc   <= calcPc;
        bank <= calcBank;
      end
    end
  end
endmodule

// File: rtl/bank_branch_unit.sv
module bank_branch_unit
  import bbu_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter int              BANK_W     = 8,
  parameter int              DISP_W     = 8,
  parameter int              VEC_W      = 4,
  parameter int              LEN_W      = 3,
  parameter int              CYC_W      = 3,
  parameter logic [PC_W-1:0]   RESET_PC   = 16'h1000,
  parameter logic [BANK_W-1:0] RESET_BANK = 8'h02,
  parameter logic [PC_W-1:0]   RESET_SP   = 16'h8000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [3:0]             opClass,
  input  logic [3:0]             condCode,
  input  logic [4:0]             flags,
  input  logic [DISP_W-1:0]      disp,
  input  logic [PC_W+BANK_W-1:0] target,
  input  logic [PC_W-1:0]        accum,
  input  logic [PC_W-1:0]        indWord,
  input  logic [BANK_W-1:0]      indBank,
  input  logic [VEC_W-1:0]       vecNum,
  input  logic [LEN_W-1:0]       instLen,
  input  logic [PC_W-1:0]        rdData,
  output logic                   busy,
  output logic                   done,
  output logic [CYC_W-1:0]       cycles,
  output logic                   taken,
  output logic [PC_W-1:0]        pc,
  output logic [BANK_W-1:0]      bank,
  output logic                   stkWe,
  output logic [PC_W-1:0]        stkAddr,
  output logic [PC_W-1:0]        stkData,
  output logic                   rdReq,
  output logic [PC_W+BANK_W-1:0] rdAddr
);
  ctrlStrobeT strobe;
  logic [3:0] opCur;
  logic       condHit;

  bbu_ctrl #(.CYC_W(CYC_W)) ctrlUnit (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opCur   (opCur),
    .condHit (condHit),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done),
    .cycles  (cycles)
  );

  bbu_datapath #(
    .PC_W(PC_W), .BANK_W(BANK_W), .DISP_W(DISP_W), .VEC_W(VEC_W),
    .LEN_W(LEN_W), .RESET_PC(RESET_PC), .RESET_BANK(RESET_BANK),
    .RESET_SP(RESET_SP)
  ) pathUnit (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opClass  (opClass),
    .condCode (condCode),
    .flags    (flags),
    .disp     (disp),
    .target   (target),
    .accum    (accum),
    .indWord  (indWord),
    .indBank  (indBank),
    .vecNum   (vecNum),
    .instLen  (instLen),
    .rdData   (rdData),
    .opCur    (opCur),
    .condHit  (condHit),
    .taken    (taken),
    .pc       (pc),
    .bank     (bank),
    .stkWe    (stkWe),
    .stkAddr  (stkAddr),
    .stkData  (stkData),
    .rdReq    (rdReq),
    .rdAddr   (rdAddr)
  );
endmodule

// File: rtl/bbu_checker.sv
module bbu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [3:0]  opClass,
  input logic        busy,
  input logic        done,
  input logic [2:0]  cycles,
  input logic        taken,
  input logic [15:0] pc,
  input logic [7:0]  bank,
  input logic        stkWe,
  input logic [15:0] stkAddr
);
  logic [3:0] recOp;
  logic [7:0] recBank;
  logic       recNear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recOp   <= 4'd15;
      recBank <= '0;
    end else if (start && !busy) begin
      recOp   <= opClass;
      recBank <= bank;
    end
  end

  assign recNear = (recOp <= 4'd4) || recOp == 4'd7 || recOp == 4'd8 || recOp == 4'd11;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_HOLD_PC_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(pc) && $stable(bank))); // R9
  AST_STACK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stkWe) && stkWe) |-> (stkAddr == $past(stkAddr) - 16'd2)); // R7
  AST_PUSH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    stkWe |-> busy); // R7
  AST_NEAR_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (done && recNear) |-> (bank == recBank)); // R5
  AST_REL_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    (done && recOp <= 4'd1) |-> (cycles == (taken ? 3'd4 : 3'd3))); // R4
endmodule

bind bank_branch_unit bbu_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opClass (opClass),
  .busy    (busy),
  .done    (done),
  .cycles  (cycles),
  .taken   (taken),
  .pc      (pc),
  .bank    (bank),
  .stkWe   (stkWe),
  .stkAddr (stkAddr)
);

// File: tb/bank_branch_unit_tb_top.sv
`timescale 1ns/1ps
module bank_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opClass = '0, condCode = '0, vecNum = '0;
  logic [4:0]  flags = '0;
  logic [7:0]  disp = '0, indBank = '0;
  logic [23:0] target = '0;
  logic [15:0] accum = '0, indWord = '0, rdData = '0;
  logic [2:0]  instLen = '0;
  logic        busy, done, taken, stkWe, rdReq;
  logic [2:0]  cycles;
  logic [15:0] pc, stkAddr, stkData;
  logic [7:0]  bank;
  logic [23:0] rdAddr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bank_branch_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opClass(opClass),
    .condCode(condCode), .flags(flags), .disp(disp), .target(target),
    .accum(accum), .indWord(indWord), .indBank(indBank), .vecNum(vecNum),
    .instLen(instLen), .rdData(rdData), .busy(busy), .done(done),
    .cycles(cycles), .taken(taken), .pc(pc), .bank(bank), .stkWe(stkWe),
    .stkAddr(stkAddr), .stkData(stkData), .rdReq(rdReq), .rdAddr(rdAddr)
  );

  function automatic logic [15:0] vecFn(input logic [23:0] a);
    return a[15:0] ^ {8'h3C, a[23:16]};
  endfunction

  // Vector table model: data one cycle after the request.
  always @(posedge clk) if (rdReq) rdData <= vecFn(rdAddr);

  function automatic bit expCond(input logic [3:0] c, input logic [4:0] f);
    bit z, cy, n, v, t;
    z = f[0]; cy = f[1]; n = f[2]; v = f[3]; t = f[4];
    case (c)
      4'd0: return z;          4'd1: return !z;
      4'd2: return cy;         4'd3: return !cy;
      4'd4: return n;          4'd5: return !n;
      4'd6: return v;          4'd7: return !v;
      4'd8: return t;          4'd9: return !t;
      4'd10: return v ^ n;     4'd11: return !(v ^ n);
      4'd12: return (v ^ n) | z;
      4'd13: return !((v ^ n) | z);
      4'd14: return cy | z;
      default: return !(cy | z);
    endcase
  endfunction

  typedef struct {
    logic [15:0] pc;
    logic [7:0]  bank;
    int          cyc;
    bit          tk;
    int          nPush;
    logic [15:0] pa [2];
    logic [15:0] pd [2];
    string       req;
  } expT;

  expT expQ[$];
  logic [15:0] mPc = 16'h1000;
  logic [7:0]  mBank = 8'h02;
  logic [15:0] mSp = 16'h8000;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: collects stack writes and compares at each done pulse.
  int gotN = 0;
  logic [15:0] gotA [4];
  logic [15:0] gotD [4];
  always @(negedge clk) begin
    if (rstN && stkWe) begin
      if (gotN < 4) begin
        gotA[gotN] = stkAddr;
        gotD[gotN] = stkData;
      end
      gotN++;
    end
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        chk("R10", "unexpected done", 1, 0);
      end else begin
        expT e;
        e = expQ.pop_front();
        chk(e.req, "pc", pc, e.pc);
        chk(e.req, "bank", bank, e.bank);
        chk(e.req, "taken", taken, e.tk);
        chk("R4", "cycles", cycles, e.cyc);
        chk("R7", "push count", gotN, e.nPush);
        for (int i = 0; i < e.nPush && i < 2 && i < gotN; i++) begin
          chk("R7", "push addr", gotA[i], e.pa[i]);
          chk("R7", "push data", gotD[i], e.pd[i]);
        end
      end
      gotN = 0;
    end
  end

  // Driver: computes expected result, queues it, then drives the request.
  task automatic doOp(input logic [3:0] op, input logic [3:0] c,
                      input logic [4:0] f, input logic [7:0] d,
                      input logic [23:0] tg, input logic [15:0] ac,
                      input logic [15:0] iw, input logic [7:0] ib,
                      input logic [3:0] v, input logic [2:0] ln,
                      input string req, input bit poke);
    expT e;
    logic [15:0] follow;
    follow = mPc + 16'(ln);
    e.pc = mPc; e.bank = mBank; e.cyc = 2; e.tk = 1'b1; e.nPush = 0;
    e.pa[0] = '0; e.pa[1] = '0; e.pd[0] = '0; e.pd[1] = '0; e.req = req;
    case (op)
      4'd0, 4'd1: begin
        e.tk  = (op == 4'd1) || expCond(c, f);
        e.pc  = e.tk ? follow + {{8{d[7]}}, d} : follow;
        e.cyc = e.tk ? 4 : 3;
      end
      4'd2: e.pc = ac;
      4'd3: e.pc = tg[15:0];
      4'd4: e.pc = iw;
      4'd5: begin e.pc = tg[15:0]; e.bank = tg[23:16]; end
      4'd6: begin e.pc = iw; e.bank = ib; end
      4'd7, 4'd8: begin
        e.pc = (op == 4'd7) ? tg[15:0] : iw;
        e.cyc = 3; e.nPush = 1; e.pa[0] = mSp - 16'd2; e.pd[0] = follow;
      end
      4'd9, 4'd10: begin
        e.pc   = (op == 4'd9) ? tg[15:0] : iw;
        e.bank = (op == 4'd9) ? tg[23:16] : ib;
        e.cyc = 4; e.nPush = 2;
        e.pa[0] = mSp - 16'd2; e.pd[0] = {8'h00, mBank};
        e.pa[1] = mSp - 16'd4; e.pd[1] = follow;
      end
      4'd11: begin
        e.pc = vecFn({mBank, 16'hFFE0 + 16'(2 * (15 - int'(v)))});
        e.cyc = 5; e.nPush = 1; e.pa[0] = mSp - 16'd2; e.pd[0] = follow;
      end
      default: e.tk = 1'b0;
    endcase
    mPc = e.pc; mBank = e.bank; mSp = mSp - 16'(2 * e.nPush);
    expQ.push_back(e);

    @(negedge clk);
    opClass = op; condCode = c; flags = f; disp = d; target = tg;
    accum = ac; indWord = iw; indBank = ib; vecNum = v; instLen = ln;
    start = 1'b1;
    @(negedge clk);
    if (poke) begin
      // R10: requests during the operation must be ignored.
      opClass = 4'd2; accum = 16'hDEAD;
      @(negedge clk);
      opClass = 4'd6; indWord = 16'hBEEF; indBank = 8'h77;
      @(negedge clk);
    end
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [4:0] pat [5];
    pat[0] = 5'h00; pat[1] = 5'h1F; pat[2] = 5'h0C; pat[3] = 5'h08; pat[4] = 5'h13;
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1", "reset pc", pc, 16'h1000);
    chk("R1", "reset bank", bank, 8'h02);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "idle pc", pc, 16'h1000);

    // R2/R3: every test under several flag patterns
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 5; k++)
        doOp(4'd0, 4'(c), pat[k], (k[0] ? 8'hF0 : 8'h12), '0, '0, '0, '0, '0,
             3'(1 + k % 3), "R2", 1'b0);
    // R3: wrap across the top and bottom of the bank
    doOp(4'd2, '0, '0, '0, '0, 16'hFFF8, '0, '0, '0, 3'd1, "R5", 1'b0);
    doOp(4'd1, '0, '0, 8'h20, '0, '0, '0, '0, '0, 3'd2, "R3", 1'b0);
    doOp(4'd3, '0, '0, '0, 24'h990004, '0, '0, '0, '0, 3'd3, "R5", 1'b0);
    doOp(4'd1, '0, '0, 8'h80, '0, '0, '0, '0, '0, 3'd1, "R3", 1'b0);
    doOp(4'd0, 4'd8, 5'h00, 8'h7F, '0, '0, '0, '0, '0, 3'd2, "R3", 1'b0);
    // R5: near jumps
    doOp(4'd4, '0, '0, '0, '0, '0, 16'h3456, 8'hAA, '0, 3'd2, "R5", 1'b0);
    // R6: far jumps
    doOp(4'd5, '0, '0, '0, 24'h41_2220, '0, '0, '0, '0, 3'd3, "R6", 1'b0);
    doOp(4'd6, '0, '0, '0, 24'h55_0000, '0, 16'h0A0B, 8'h13, '0, 3'd2, "R6", 1'b0);
    // R7: calls
    doOp(4'd7, '0, '0, '0, 24'hEE_5000, '0, '0, '0, '0, 3'd3, "R7", 1'b0);
    doOp(4'd8, '0, '0, '0, '0, '0, 16'h6000, '0, '0, 3'd2, "R7", 1'b0);
    doOp(4'd9, '0, '0, '0, 24'h3C_7000, '0, '0, '0, '0, 3'd4, "R7", 1'b0);
    doOp(4'd10, '0, '0, '0, '0, '0, 16'h7100, 8'h08, '0, 3'd1, "R7", 1'b0);
    // R8: vector calls at both table ends and in the middle
    doOp(4'd11, '0, '0, '0, '0, '0, '0, '0, 4'd0, 3'd1, "R8", 1'b0);
    doOp(4'd11, '0, '0, '0, '0, '0, '0, '0, 4'd15, 3'd1, "R8", 1'b0);
    doOp(4'd11, '0, '0, '0, '0, '0, '0, '0, 4'd5, 3'd1, "R8", 1'b0);
    // R10: start held during a far call
    doOp(4'd9, '0, '0, '0, 24'h21_4321, '0, '0, '0, '0, 3'd3, "R10", 1'b1);
    // R11: unused classes
    doOp(4'd13, '0, '0, '0, 24'hFF_FFFF, 16'h1111, '0, '0, '0, 3'd3, "R11", 1'b0);
    doOp(4'd15, '0, '0, '0, '0, 16'h2222, '0, '0, '0, 3'd3, "R11", 1'b0);

    repeat (6) @(negedge clk);
    // R9: single pulse per operation, nothing left pending
    chk("R9", "pending results", expQ.size(), 0);
    chk("R9", "done idle", done, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule